// File: doc/BRIEF.md
# Scan and Conversion Pacer Clock Generator

This block makes the two timing strobes for a multi-channel analog acquisition front end, running on a 100 MHz base clock. The scan strobe marks the start of each pass over the channel list. The conversion strobe paces the single conversions inside a pass. Each strobe comes from one of two places: its own internal down-counting divider, or an external input. The external input first goes through a two-flop synchronizer and a rising-edge detector. The scan strobe can also be slaved to the external conversion input, so that one outside clock drives both strobes.

Software programs the block through a simple write port with three registers, described under the requirements below. The source selectors and the divisors can only change while pacing is off. The block raises two sticky flags. One reports an external edge that came too soon after the previous accepted edge. The other reports a bad configuration. The block carries no sample data, so it has no valid/ready stream. Every pin is a plain control or status signal, and the strobes are one-cycle pulses with no back-pressure.

Top module: `pacer_clkgen`

## Requirements
- R1: After reset, `scan_stb`, `conv_stb`, `rate_err` and `cfg_err` are 0. Pacing is off, both sources are internal, and both divisors hold MIN_DIV (200).
- R2: Writes go through a single port. Address 0 is the control register: bit 0 enable; bits 2:1 scan source (00 internal, 01 external scan input, 10 external conversion input, 11 internal); bit 3 conversion source (0 internal, 1 external); bit 8 flag clear. Address 1 holds the scan divisor and address 2 the conversion divisor. While pacing is enabled with an internal source, a divisor N gives a one-cycle strobe every N cycles. The first strobe comes N cycles after the clock edge that enables pacing.
- R3: A divisor written below MIN_DIV is stored as MIN_DIV. This applies to both divisors.
- R4: With the scan source set to the external scan input, each accepted rising edge of `ext_scan_in` gives one scan strobe. The strobe appears on the third clock edge after the input rises.
- R5: With the conversion source set to external, each accepted rising edge of `ext_conv_in` gives one conversion strobe, with the same three-edge latency.
- R6: With the scan source set to the external conversion input, each accepted `ext_conv_in` edge gives a scan strobe and a conversion strobe in the same cycle, whatever the conversion source bit says.
- R7: An external edge that comes fewer than MIN_DIV cycles after the previous accepted edge on the same input is dropped, and it sets `rate_err`.
- R8: A control write that enables pacing sets `cfg_err` when both of these hold: the scan divisor is smaller than the conversion divisor, and both sources end up internal. Pacing still starts.
- R9: While pacing is enabled, a write to either divisor, or a control write whose source fields differ from the current ones, leaves the divisors and sources unchanged and sets `cfg_err`.
- R10: Both flags stay set until a control write with bit 8 set clears them. If an error occurs on that same edge, the error wins and the flag stays 1.
- R11: While pacing is off, no strobe is produced, and external edges neither make strobes nor set `rate_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | DIV_W | Register write data |
| ext_scan_in | input | 1 | Asynchronous external scan clock |
| ext_conv_in | input | 1 | Asynchronous external conversion clock |
| scan_stb | output | 1 | One-cycle scan start pulse |
| conv_stb | output | 1 | One-cycle conversion pulse |
| rate_err | output | 1 | Sticky flag for an external edge that came too soon |
| cfg_err | output | 1 | Sticky flag for a bad configuration |

## Verification
Two things can land on the same clock edge: an error that sets `cfg_err` and a flag-clear write. The bench provokes this with a control write that sets the clear bit and also tries to change a source while pacing runs. It then expects the flag to read 1. The scan and conversion strobes can also coincide, both with internal divisors of 400 and 200 and in the slaved mode. A behavioural model predicts each strobe cycle by cycle, and every cycle's outputs are compared against it.

// File: rtl/pacer_pkg.sv
`timescale 1ns/1ps
package pacer_pkg;
  typedef enum logic [1:0] {
    SCAN_INT     = 2'b00,
    SCAN_EXT     = 2'b01,
    SCAN_CONVIN  = 2'b10,
    SCAN_INT_ALT = 2'b11
  } scan_src_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_SDIV = 2'd1;
  localparam logic [1:0] ADDR_CDIV = 2'd2;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_SLO = 1;
  localparam int CTRL_SHI = 2;
  localparam int CTRL_CX  = 3;
  localparam int CTRL_CLR = 8;
endpackage

// File: rtl/pacer_div.sv
`timescale 1ns/1ps
module pacer_div #(
  parameter int DIV_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run)         cnt <= div - 1'b1;
    else if (cnt == '0)    cnt <= div - 1'b1;
    else                   cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/pacer_edge.sv
`timescale 1ns/1ps
module pacer_edge #(
  parameter int MIN_GAP = 200,
  localparam int GAP_W  = $clog2(MIN_GAP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  input  logic active,
  output logic accept,
  output logic early
);
  logic meta_q, sync_q, prev_q, rise;
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise   = sync_q && !prev_q;
  assign accept = active && rise && (gap == '0);
  assign early  = active && rise && (gap != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gap <= '0;
    else if (!active)   gap <= '0;
    else if (accept)    gap <= GAP_W'(MIN_GAP - 1);
    else if (gap != '0) gap <= gap - 1'b1;
  end
endmodule

// File: rtl/pacer_regs.sv
`timescale 1ns/1ps
module pacer_regs
  import pacer_pkg::*;
#(
  parameter int DIV_W   = 32,
  parameter int MIN_DIV = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DIV_W-1:0] wr_data,
  input  logic             rate_evt,
  output logic             en_q,
  output scan_src_e        scan_src_q,
  output logic             conv_ext_q,
  output logic [DIV_W-1:0] scan_div_q,
  output logic [DIV_W-1:0] conv_div_q,
  output logic             cfg_err_q,
  output logic             rate_err_q
);
  localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_DIV);

  logic      ctrl_wr, div_wr, clr, src_diff, lock_hit, ratio_hit, scan_int_new;
  scan_src_e new_src;

  function automatic logic [DIV_W-1:0] floor_div(input logic [DIV_W-1:0] v);
    return (v < FLOOR) ? FLOOR : v;
  endfunction

  assign ctrl_wr      = wr_en && (wr_addr == ADDR_CTRL);
  assign div_wr       = wr_en && ((wr_addr == ADDR_SDIV) || (wr_addr == ADDR_CDIV));
  assign clr          = ctrl_wr && wr_data[CTRL_CLR];
  assign new_src      = scan_src_e'(wr_data[CTRL_SHI:CTRL_SLO]);
  assign src_diff     = (new_src != scan_src_q) || (wr_data[CTRL_CX] != conv_ext_q);
  assign lock_hit     = en_q && (div_wr || (ctrl_wr && src_diff));
  assign scan_int_new = (new_src == SCAN_INT) || (new_src == SCAN_INT_ALT);
  assign ratio_hit    = ctrl_wr && !en_q && wr_data[CTRL_EN] && scan_int_new &&
                        !wr_data[CTRL_CX] && (scan_div_q < conv_div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      scan_src_q <= SCAN_INT;
      conv_ext_q <= 1'b0;
      scan_div_q <= FLOOR;
      conv_div_q <= FLOOR;
      cfg_err_q  <= 1'b0;
      rate_err_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en_q <= wr_data[CTRL_EN];
        if (!en_q) begin
          scan_src_q <= new_src;
          conv_ext_q <= wr_data[CTRL_CX];
        end
      end
      if (wr_en && !en_q && (wr_addr == ADDR_SDIV)) scan_div_q <= floor_div(wr_data);
      if (wr_en && !en_q && (wr_addr == ADDR_CDIV)) conv_div_q <= floor_div(wr_data);
      if (lock_hit || ratio_hit) cfg_err_q <= 1'b1;
      else if (clr)              cfg_err_q <= 1'b0;
      if (rate_evt)              rate_err_q <= 1'b1;
      else if (clr)              rate_err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pacer_clkgen.sv
`timescale 1ns/1ps
module pacer_clkgen
  import pacer_pkg::*;
#(
  parameter int DIV_W   = 32,
  parameter int MIN_DIV = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DIV_W-1:0] wr_data,
  input  logic             ext_scan_in,
  input  logic             ext_conv_in,
  output logic             scan_stb,
  output logic             conv_stb,
  output logic             rate_err,
  output logic             cfg_err
);
  logic             en_q, conv_ext_q;
  scan_src_e        scan_src_q;
  logic [DIV_W-1:0] scan_div_q, conv_div_q;
  logic             scan_int, conv_from_ext;
  logic             s_tick, c_tick;
  logic             sx_acc, sx_early, cx_acc, cx_early;
  logic             scan_d, conv_d;

  pacer_regs #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rate_evt(sx_early || cx_early), .en_q(en_q), .scan_src_q(scan_src_q),
    .conv_ext_q(conv_ext_q), .scan_div_q(scan_div_q), .conv_div_q(conv_div_q),
    .cfg_err_q(cfg_err), .rate_err_q(rate_err)
  );

  assign scan_int      = (scan_src_q == SCAN_INT) || (scan_src_q == SCAN_INT_ALT);
  assign conv_from_ext = conv_ext_q || (scan_src_q == SCAN_CONVIN);

  pacer_div #(.DIV_W(DIV_W)) u_sdiv (
    .clk(clk), .rst_n(rst_n), .run(en_q && scan_int), .div(scan_div_q), .tick(s_tick)
  );
  pacer_div #(.DIV_W(DIV_W)) u_cdiv (
    .clk(clk), .rst_n(rst_n), .run(en_q && !conv_from_ext), .div(conv_div_q), .tick(c_tick)
  );

  pacer_edge #(.MIN_GAP(MIN_DIV)) u_sedge (
    .clk(clk), .rst_n(rst_n), .async_in(ext_scan_in),
    .active(en_q && (scan_src_q == SCAN_EXT)), .accept(sx_acc), .early(sx_early)
  );
  pacer_edge #(.MIN_GAP(MIN_DIV)) u_cedge (
    .clk(clk), .rst_n(rst_n), .async_in(ext_conv_in),
    .active(en_q && conv_from_ext), .accept(cx_acc), .early(cx_early)
  );

  always_comb begin
    if (scan_int)                      scan_d = s_tick;
    else if (scan_src_q == SCAN_EXT)   scan_d = sx_acc;
    else                               scan_d = cx_acc;
    conv_d = conv_from_ext ? cx_acc : c_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_stb <= 1'b0;
      conv_stb <= 1'b0;
    end else begin
      scan_stb <= scan_d;
      conv_stb <= conv_d;
    end
  end
endmodule

// File: rtl/pacer_clkgen_chk.sv
`timescale 1ns/1ps
module pacer_clkgen_chk #(
  parameter int DIV_W   = 32,
  parameter int MIN_DIV = 200
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [DIV_W-1:0] wr_data,
  input logic             en_q,
  input logic [1:0]       scan_src_q,
  input logic [DIV_W-1:0] scan_div_q,
  input logic [DIV_W-1:0] conv_div_q,
  input logic             scan_stb,
  input logic             conv_stb,
  input logic             rate_err,
  input logic             cfg_err
);
  logic clr_wr;
  assign clr_wr = wr_en && (wr_addr == 2'd0) && wr_data[8];

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (!scan_stb && !conv_stb));

  p_shared_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && scan_src_q == 2'b10) |=> (scan_stb == conv_stb));

  p_cfg_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !clr_wr) |=> cfg_err);

  p_rate_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_err && !clr_wr) |=> rate_err);

  p_div_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_div_q >= DIV_W'(MIN_DIV)) && (conv_div_q >= DIV_W'(MIN_DIV)));

  p_sdiv_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && wr_en && wr_addr == 2'd1) |=> ($stable(scan_div_q) && cfg_err));

  p_cdiv_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && wr_en && wr_addr == 2'd2) |=> ($stable(conv_div_q) && cfg_err));
endmodule

bind pacer_clkgen pacer_clkgen_chk #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .en_q(en_q), .scan_src_q(scan_src_q), .scan_div_q(scan_div_q),
  .conv_div_q(conv_div_q), .scan_stb(scan_stb), .conv_stb(conv_stb),
  .rate_err(rate_err), .cfg_err(cfg_err)
);

// File: tb/pacer_clkgen_tb_top.sv
`timescale 1ns/1ps
module pacer_clkgen_tb_top;
  localparam int MIND = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        ext_scan_in = 1'b0, ext_conv_in = 1'b0;
  logic        scan_stb, conv_stb, rate_err, cfg_err;

  int    total = 0, bad = 0;
  string cur_req = "R1";
  int    n_scan = 0, n_conv = 0;

  always #2 clk = ~clk;

  pacer_clkgen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_scan_in(ext_scan_in), .ext_conv_in(ext_conv_in),
    .scan_stb(scan_stb), .conv_stb(conv_stb), .rate_err(rate_err), .cfg_err(cfg_err)
  );

  // behavioural reference model, advanced on every rising edge
  int m_en, m_ssrc, m_cext, m_sdiv, m_cdiv, m_k, gs, gc;
  int m_cfg, m_rate, e_scan, e_conv;
  bit hs[3], hc[3];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_ssrc = 0; m_cext = 0; m_sdiv = MIND; m_cdiv = MIND; m_k = 0;
      gs = 0; gc = 0; m_cfg = 0; m_rate = 0; e_scan = 0; e_conv = 0;
      foreach (hs[i]) begin hs[i] = 0; hc[i] = 0; end
    end else begin
      bit s_int, c_ext, use_s, use_c, sedge, cedge, s_acc, c_acc, early;
      bit tick_s, tick_c, lockv, ratio, clr;
      s_int = (m_ssrc == 0) || (m_ssrc == 3);
      c_ext = (m_cext == 1) || (m_ssrc == 2);
      use_s = (m_en == 1) && (m_ssrc == 1);
      use_c = (m_en == 1) && c_ext;
      sedge = hs[1] && !hs[2];
      cedge = hc[1] && !hc[2];
      s_acc = use_s && sedge && gs == 0;
      c_acc = use_c && cedge && gc == 0;
      early = (use_s && sedge && gs != 0) || (use_c && cedge && gc != 0);
      if (!use_s) gs = 0; else if (s_acc) gs = MIND - 1; else if (gs > 0) gs--;
      if (!use_c) gc = 0; else if (c_acc) gc = MIND - 1; else if (gc > 0) gc--;
      tick_s = 0; tick_c = 0;
      if (m_en == 1) begin
        m_k++;
        tick_s = s_int && (m_k % m_sdiv == 0);
        tick_c = !c_ext && (m_k % m_cdiv == 0);
      end else m_k = 0;
      e_scan = s_int ? tick_s : (m_ssrc == 1 ? s_acc : c_acc);
      e_conv = c_ext ? c_acc : tick_c;
      lockv = 0; ratio = 0; clr = 0;
      if (wr_en) begin
        int d;
        d = int'(wr_data);
        if (wr_addr == 0) begin
          int ns, nc;
          ns = (d >> 1) & 3; nc = (d >> 3) & 1;
          clr = wr_data[8];
          if (m_en == 1) lockv = (ns != m_ssrc) || (nc != m_cext);
          else begin
            ratio = wr_data[0] && (ns == 0 || ns == 3) && nc == 0 && m_sdiv < m_cdiv;
            m_ssrc = ns; m_cext = nc;
          end
          m_en = wr_data[0];
        end else if (wr_addr == 1 || wr_addr == 2) begin
          if (m_en == 1) lockv = 1;
          else if (wr_addr == 1) m_sdiv = (wr_data < MIND) ? MIND : d;
          else m_cdiv = (wr_data < MIND) ? MIND : d;
        end
      end
      if (lockv || ratio) m_cfg = 1; else if (clr) m_cfg = 0;
      if (early) m_rate = 1; else if (clr) m_rate = 0;
      hs[2] = hs[1]; hs[1] = hs[0]; hs[0] = ext_scan_in;
      hc[2] = hc[1]; hc[1] = hc[0]; hc[0] = ext_conv_in;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, "scan_stb", int'(scan_stb), e_scan);
      check(cur_req, "conv_stb", int'(conv_stb), e_conv);
      check(cur_req, "rate_err", int'(rate_err), m_rate);
      check(cur_req, "cfg_err",  int'(cfg_err),  m_cfg);
    end
  end

  always @(posedge clk) begin
    if (scan_stb) n_scan++;
    if (conv_stb) n_conv++;
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit conv);
    @(negedge clk);
    if (conv) ext_conv_in = 1'b1; else ext_scan_in = 1'b1;
    idle(3);
    ext_conv_in = 1'b0; ext_scan_in = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int s0, c0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state and default divisors
    check("R1", "scan_stb", int'(scan_stb), 0);
    check("R1", "conv_stb", int'(conv_stb), 0);
    check("R1", "rate_err", int'(rate_err), 0);
    check("R1", "cfg_err",  int'(cfg_err),  0);
    wr(0, 32'h1); s0 = n_scan; c0 = n_conv; idle(450);
    check("R1", "default scan count", n_scan - s0, 2);
    check("R1", "default conv count", n_conv - c0, 2);
    wr(0, 32'h0);

    // R2 internal pacing, coincident strobes every 400 cycles
    cur_req = "R2";
    wr(1, 400); wr(2, 200);
    wr(0, 32'h1); s0 = n_scan; c0 = n_conv; idle(1100);
    check("R2", "scan count", n_scan - s0, 2);
    check("R2", "conv count", n_conv - c0, 5);
    wr(0, 32'h0);

    // R3 clamping to the floor
    cur_req = "R3";
    wr(1, 10); wr(2, 50);
    wr(0, 32'h1); s0 = n_scan; c0 = n_conv; idle(1100);
    check("R3", "scan count", n_scan - s0, 5);
    check("R3", "conv count", n_conv - c0, 5);
    check("R3", "cfg_err", int'(cfg_err), 0);

    // R9 locked writes while enabled, R10 clear and error-wins
    cur_req = "R9";
    wr(1, 500); idle(2);
    check("R9", "cfg_err after locked write", int'(cfg_err), 1);
    s0 = n_scan; idle(400);
    check("R9", "scan divisor kept", n_scan - s0, 2);
    cur_req = "R10";
    wr(0, 32'h101); idle(2);
    check("R10", "cfg_err cleared", int'(cfg_err), 0);
    wr(0, 32'h103); idle(2);
    check("R10", "error wins over clear", int'(cfg_err), 1);
    wr(0, 32'h100); idle(2);
    check("R10", "cfg_err cleared when stopping", int'(cfg_err), 0);

    // R8 scan faster than conversion
    cur_req = "R8";
    wr(1, 200); wr(2, 300); wr(0, 32'h1); idle(2);
    check("R8", "cfg_err on enable", int'(cfg_err), 1);
    idle(400);
    wr(0, 32'h100); idle(2);

    // R4 external scan input, R7 early edge
    cur_req = "R4";
    wr(0, 32'h2); wr(0, 32'h3); idle(5);
    s0 = n_scan;
    for (int i = 0; i < 3; i++) begin pulse(0); idle(250); end
    cur_req = "R7";
    pulse(0); idle(40); pulse(0); idle(20);
    check("R4", "ext scan strobes", n_scan - s0, 4);
    check("R7", "rate_err set", int'(rate_err), 1);
    wr(0, 32'h102); idle(2);
    check("R10", "rate_err cleared", int'(rate_err), 0);

    // R5 external conversion input
    cur_req = "R5";
    wr(0, 32'h8); wr(0, 32'h9); idle(5);
    c0 = n_conv;
    for (int i = 0; i < 3; i++) begin pulse(1); idle(250); end
    check("R5", "ext conv strobes", n_conv - c0, 3);
    wr(0, 32'h8);

    // R6 scan slaved to conversion input
    cur_req = "R6";
    wr(0, 32'h4); wr(0, 32'h5); idle(5);
    s0 = n_scan; c0 = n_conv;
    for (int i = 0; i < 3; i++) begin pulse(1); idle(210); end
    check("R6", "slaved scan strobes", n_scan - s0, 3);
    check("R6", "slaved conv strobes", n_conv - c0, 3);

    // R11 disabled: edges ignored
    cur_req = "R11";
    wr(0, 32'h104); idle(3);
    s0 = n_scan; c0 = n_conv;
    pulse(1); pulse(0); pulse(1); idle(30);
    check("R11", "no scan when off", n_scan - s0, 0);
    check("R11", "no conv when off", n_conv - c0, 0);
    check("R11", "rate_err stays clear", int'(rate_err), 0);
    finish_run();
  end
endmodule